// File: doc/BRIEF.md
# Byte-Command Serial Host Port

This block is a serial slave that lets a host processor write a coefficient RAM and write or read a bank of eight-bit control registers over three wires: a serial clock, a data-in line and an active-low select. Every transaction starts with a command byte. Bit 7 of that byte gives the direction, and the other bits choose the target. A coefficient command also carries a burst length in its low nibble and is followed by a two-byte start address and 24-bit words. A register command is followed by a single data byte, which the host sends on a write and the block returns on a read.

All inputs are oversampled by the system clock `clk`, so the serial clock must be slow compared with `clk`, with at least four `clk` periods in each phase. While select is low, the data-out line returns every received bit eight bit periods late. The only exception is the byte slot after a register read command, where the line carries the register contents. Each coefficient word leaves the block on a valid/ready port. The transfer happens on a cycle where `coef_valid` and `coef_ready` are both high. While `coef_valid` is high and `coef_ready` is low, the address and data are held stable and `host_rdy` stays low. A sink may hold `coef_ready` low for any length of time. The host is expected to poll `host_rdy` before it starts a transaction or sends another word.

Top module: `hostif_serial_slave`

## Requirements
- R1: After reset, `host_rdy` is 1, `host_sdo` is 0, `coef_valid` is 0 and neither register strobe is asserted.
- R2: While `host_sel_n` is 0, one bit of `host_sdi` is taken on each rising edge of `host_sclk`. Bytes are assembled most significant bit first, and the first byte is the command.
- R3: Outside a read data slot, `host_sdo` during bit period n of a transaction equals the bit received in period n-8. It is 0 during the first eight periods.
- R4: Command bytes 80h to 8Fh start a coefficient burst of (low nibble + 1) words. The next two bytes form the 12-bit start address: the low nibble of the first byte supplies address bits 11:8 (its upper nibble is ignored) and the second byte supplies bits 7:0.
- R5: Every three data bytes after the address form one 24-bit word, first byte most significant. Each word produces one transfer on the coefficient port, and the address rises by one per word, wrapping from FFFh to 000h.
- R6: Words received after the burst count is used up produce no transfer.
- R7: While `coef_valid` is 1 and `coef_ready` is 0, `coef_addr` and `coef_data` are held stable and `host_rdy` is 0. A word completed in that state is dropped, but it still counts toward the burst.
- R8: If a command byte completes while `host_rdy` is 0, the whole transaction is ignored.
- R9: Command bytes 40h-4Dh and 50h-57h are register reads. Each one pulses `reg_rd_en` for one cycle with `reg_rd_addr` equal to command bits 4:0. `reg_rd_data` is sampled on the cycle after the pulse and driven on `host_sdo` most significant bit first over the next eight bit periods. The echo then resumes.
- R10: Command bytes C0h-CDh and D0h-D7h are register writes. The next byte pulses `reg_wr_en` for one cycle, with `reg_wr_addr` equal to command bits 4:0 and `reg_wr_data` equal to that byte. Any further bytes are ignored.
- R11: Any other command byte causes no strobe and no transfer for the rest of the transaction.
- R12: Raising `host_sel_n` aborts the transaction. A partly received word is dropped, and the next transaction begins again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sclk | input | 1 | Serial bit clock from the host |
| host_sdi | input | 1 | Serial data from the host |
| host_sel_n | input | 1 | Active-low transaction select |
| host_sdo | output | 1 | Echo or register read data to the host |
| host_rdy | output | 1 | High when a new command will be accepted |
| coef_valid | output | 1 | Coefficient word available |
| coef_ready | input | 1 | Coefficient sink accepts the word |
| coef_addr | output | 12 | Coefficient word address |
| coef_data | output | 24 | Coefficient word data |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | 5 | Register write index |
| reg_wr_data | output | 8 | Register write value |
| reg_rd_en | output | 1 | Register read strobe |
| reg_rd_addr | output | 5 | Register read index |
| reg_rd_data | input | 8 | Register read value |

## Verification
A corrupted receive shift register shows on `host_sdo` within eight bit periods, because every bit period is compared against the delayed copy of the host stream. A wrong burst counter or address counter appears as a missing, extra or misaddressed transfer on the coefficient port, and it is caught on the very cycle of the handshake. A stuck pending flag is caught one transaction later, either as a register write that should have been dropped or as a `host_rdy` that stays low after the sink is released.

// File: rtl/hostif_pkg.sv
package hostif_pkg;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_COEF,
    ST_REG_WR,
    ST_REG_RD,
    ST_SKIP
  } hif_state_e;

  localparam int REG_AW    = 5;
  localparam int BURST_MAX = 16;

  // Register index space reachable by the read/write command codes.
  function automatic logic reg_idx_ok(input logic [REG_AW-1:0] idx);
    return (idx <= 5'd13) || ((idx >= 5'd16) && (idx <= 5'd23));
  endfunction

  // Low seven bits of a command byte that address a control register.
  function automatic logic reg_code_ok(input logic [6:0] c);
    return ((c >= 7'h40) && (c <= 7'h4D)) || ((c >= 7'h50) && (c <= 7'h57));
  endfunction

endpackage

// File: rtl/hostif_bit_rx.sv
module hostif_bit_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       sdi_i,
  input  logic       sel_n_i,
  output logic       active_o,
  output logic       bit_stb_o,
  output logic       byte_stb_o,
  output logic [7:0] byte_o,
  output logic       echo_o
);
  localparam int SW = SYNC_STAGES;

  logic [SW-1:0] sclk_s, sdi_s, sel_s;
  logic          sclk_q;
  logic [7:0]    shreg;
  logic [2:0]    bit_cnt;
  logic          bit_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      sdi_s  <= '0;
      sel_s  <= '1;
      sclk_q <= 1'b0;
    end else begin
      sclk_s[0] <= sclk_i;
      sdi_s[0]  <= sdi_i;
      sel_s[0]  <= sel_n_i;
      for (int i = 1; i < SW; i++) begin
        sclk_s[i] <= sclk_s[i-1];
        sdi_s[i]  <= sdi_s[i-1];
        sel_s[i]  <= sel_s[i-1];
      end
      sclk_q <= sclk_s[SW-1];
    end
  end

  assign active_o  = ~sel_s[SW-1];
  assign bit_stb_o = active_o & sclk_s[SW-1] & ~sclk_q;
  assign bit_now   = sdi_s[SW-1];

  // One shift register assembles bytes and provides the eight-bit echo delay.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      bit_cnt    <= '0;
      byte_stb_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_stb_o <= 1'b0;
      if (!active_o) begin
        shreg   <= '0;
        bit_cnt <= '0;
      end else if (bit_stb_o) begin
        shreg   <= {shreg[6:0], bit_now};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_stb_o <= 1'b1;
          byte_o     <= {shreg[6:0], bit_now};
        end
      end
    end
  end

  assign echo_o = shreg[7];

endmodule

// File: rtl/hostif_cmd_fsm.sv
module hostif_cmd_fsm
  import hostif_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              byte_stb_i,
  input  logic [7:0]        byte_i,
  input  logic              busy_i,
  output logic              reg_wr_en_o,
  output logic [REG_AW-1:0] reg_wr_addr_o,
  output logic [7:0]        reg_wr_data_o,
  output logic              reg_rd_en_o,
  output logic [REG_AW-1:0] reg_rd_addr_o,
  output logic              word_stb_o,
  output logic [AW-1:0]     word_addr_o,
  output logic [DW-1:0]     word_data_o
);
  localparam int BPW   = DW / 8;
  localparam int BW    = (BPW > 1) ? $clog2(BPW) : 1;
  localparam int HI_W  = AW - 8;
  localparam int CNT_W = $clog2(BURST_MAX + 1);

  hif_state_e        state;
  logic [REG_AW-1:0] cmd_idx;
  logic [AW-1:0]     addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [BW-1:0]     bcnt_q;
  logic [DW-9:0]     acc_q;
  logic [DW-1:0]     word_next;

  assign word_next = {acc_q, byte_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_CMD;
      cmd_idx       <= '0;
      addr_q        <= '0;
      left_q        <= '0;
      bcnt_q        <= '0;
      acc_q         <= '0;
      reg_wr_en_o   <= 1'b0;
      reg_wr_addr_o <= '0;
      reg_wr_data_o <= '0;
      reg_rd_en_o   <= 1'b0;
      reg_rd_addr_o <= '0;
      word_stb_o    <= 1'b0;
      word_addr_o   <= '0;
      word_data_o   <= '0;
    end else begin
      reg_wr_en_o <= 1'b0;
      reg_rd_en_o <= 1'b0;
      word_stb_o  <= 1'b0;
      if (!active_i) begin
        state  <= ST_CMD;
        bcnt_q <= '0;
      end else if (byte_stb_i) begin
        unique case (state)
          ST_CMD: begin
            cmd_idx <= byte_i[REG_AW-1:0];
            bcnt_q  <= '0;
            if (busy_i) begin
              state <= ST_SKIP;
            end else if (byte_i[7:4] == 4'h8) begin
              left_q <= CNT_W'(byte_i[3:0]) + CNT_W'(1);
              state  <= ST_ADDR_HI;
            end else if (reg_code_ok(byte_i[6:0])) begin
              if (byte_i[7]) begin
                state <= ST_REG_WR;
              end else begin
                state         <= ST_REG_RD;
                reg_rd_en_o   <= 1'b1;
                reg_rd_addr_o <= byte_i[REG_AW-1:0];
              end
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_ADDR_HI: begin
            addr_q[AW-1:8] <= byte_i[HI_W-1:0];
            state          <= ST_ADDR_LO;
          end
          ST_ADDR_LO: begin
            addr_q[7:0] <= byte_i;
            state       <= ST_COEF;
          end
          ST_COEF: begin
            acc_q <= word_next[DW-9:0];
            if (bcnt_q == BW'(BPW - 1)) begin
              bcnt_q      <= '0;
              word_stb_o  <= 1'b1;
              word_addr_o <= addr_q;
              word_data_o <= word_next;
              addr_q      <= addr_q + AW'(1);
              left_q      <= left_q - CNT_W'(1);
              if (left_q == CNT_W'(1)) state <= ST_SKIP;
            end else begin
              bcnt_q <= bcnt_q + BW'(1);
            end
          end
          ST_REG_WR: begin
            reg_wr_en_o   <= 1'b1;
            reg_wr_addr_o <= cmd_idx;
            reg_wr_data_o <= byte_i;
            state         <= ST_SKIP;
          end
          ST_REG_RD: state <= ST_SKIP;
          default:   state <= ST_SKIP;
        endcase
      end
    end
  end

endmodule

// File: rtl/hostif_coef_port.sv
module hostif_coef_port #(
  parameter int AW = 12,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_stb_i,
  input  logic [AW-1:0] word_addr_i,
  input  logic [DW-1:0] word_data_i,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  // Single holding stage; a word arriving while it is occupied is dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      if (valid_o && ready_i) valid_o <= 1'b0;
      if (word_stb_i && !valid_o) begin
        valid_o <= 1'b1;
        addr_o  <= word_addr_i;
        data_o  <= word_data_i;
      end
    end
  end

endmodule

// File: rtl/hostif_tx_mux.sv
module hostif_tx_mux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_i,
  input  logic       bit_stb_i,
  input  logic       rd_req_i,
  input  logic [7:0] rd_data_i,
  input  logic       echo_i,
  output logic       sdo_o
);
  logic       load_q;
  logic [7:0] out_q;
  logic [3:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      out_q  <= '0;
      left_q <= '0;
    end else begin
      load_q <= rd_req_i & active_i;
      if (!active_i) begin
        left_q <= '0;
      end else if (load_q) begin
        out_q  <= rd_data_i;
        left_q <= 4'd8;
      end else if (bit_stb_i && (left_q != 4'd0)) begin
        out_q  <= {out_q[6:0], 1'b0};
        left_q <= left_q - 4'd1;
      end
    end
  end

  assign sdo_o = (left_q != 4'd0) ? out_q[7] : echo_i;

endmodule

// File: rtl/hostif_serial_slave.sv
module hostif_serial_slave
  import hostif_pkg::*;
#(
  parameter int AW          = 12,
  parameter int DW          = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sclk,
  input  logic              host_sdi,
  input  logic              host_sel_n,
  output logic              host_sdo,
  output logic              host_rdy,
  output logic              coef_valid,
  input  logic              coef_ready,
  output logic [AW-1:0]     coef_addr,
  output logic [DW-1:0]     coef_data,
  output logic              reg_wr_en,
  output logic [REG_AW-1:0] reg_wr_addr,
  output logic [7:0]        reg_wr_data,
  output logic              reg_rd_en,
  output logic [REG_AW-1:0] reg_rd_addr,
  input  logic [7:0]        reg_rd_data
);
  logic          active, bit_stb, byte_stb, echo;
  logic [7:0]    rx_byte;
  logic          word_stb;
  logic [AW-1:0] word_addr;
  logic [DW-1:0] word_data;

  hostif_bit_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_i(host_sclk), .sdi_i(host_sdi), .sel_n_i(host_sel_n),
    .active_o(active), .bit_stb_o(bit_stb), .byte_stb_o(byte_stb),
    .byte_o(rx_byte), .echo_o(echo)
  );

  hostif_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .active_i(active), .byte_stb_i(byte_stb), .byte_i(rx_byte),
    .busy_i(coef_valid),
    .reg_wr_en_o(reg_wr_en), .reg_wr_addr_o(reg_wr_addr), .reg_wr_data_o(reg_wr_data),
    .reg_rd_en_o(reg_rd_en), .reg_rd_addr_o(reg_rd_addr),
    .word_stb_o(word_stb), .word_addr_o(word_addr), .word_data_o(word_data)
  );

  hostif_coef_port #(.AW(AW), .DW(DW)) u_port (
    .clk(clk), .rst_n(rst_n),
    .word_stb_i(word_stb), .word_addr_i(word_addr), .word_data_i(word_data),
    .valid_o(coef_valid), .ready_i(coef_ready),
    .addr_o(coef_addr), .data_o(coef_data)
  );

  hostif_tx_mux u_tx (
    .clk(clk), .rst_n(rst_n),
    .active_i(active), .bit_stb_i(bit_stb),
    .rd_req_i(reg_rd_en), .rd_data_i(reg_rd_data),
    .echo_i(echo), .sdo_o(host_sdo)
  );

  assign host_rdy = ~coef_valid;

endmodule

// File: rtl/hostif_serial_slave_chk.sv
module hostif_serial_slave_chk
  import hostif_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rdy,
  input logic              coef_valid,
  input logic              coef_ready,
  input logic [AW-1:0]     coef_addr,
  input logic [DW-1:0]     coef_data,
  input logic              reg_wr_en,
  input logic [REG_AW-1:0] reg_wr_addr,
  input logic              reg_rd_en,
  input logic [REG_AW-1:0] reg_rd_addr
);
  assert_coef_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && !coef_ready) |=> (coef_valid && $stable(coef_addr) && $stable(coef_data)));

  assert_load_only_when_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coef_valid) |-> $past(host_rdy));

  assert_wr_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  assert_wr_index_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> reg_idx_ok(reg_wr_addr));

  assert_rd_index_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |-> reg_idx_ok(reg_rd_addr));

  assert_rd_wr_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_en && reg_wr_en));

endmodule

bind hostif_serial_slave hostif_serial_slave_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rdy(host_rdy),
  .coef_valid(coef_valid), .coef_ready(coef_ready),
  .coef_addr(coef_addr), .coef_data(coef_data),
  .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
  .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr)
);

// File: tb/hostif_serial_slave_tb_top.sv
module hostif_serial_slave_tb_top;
  localparam int AW = 12;
  localparam int DW = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, sclk, sdi, sel_n, stall;
  logic          host_sdo, host_rdy, coef_valid, coef_ready;
  logic [AW-1:0] coef_addr;
  logic [DW-1:0] coef_data;
  logic          reg_wr_en, reg_rd_en;
  logic [4:0]    reg_wr_addr, reg_rd_addr;
  logic [7:0]    reg_wr_data, reg_rd_data;

  assign coef_ready  = ~stall;
  assign reg_rd_data = {3'b101, reg_rd_addr};

  hostif_serial_slave #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_sclk(sclk), .host_sdi(sdi), .host_sel_n(sel_n),
    .host_sdo(host_sdo), .host_rdy(host_rdy),
    .coef_valid(coef_valid), .coef_ready(coef_ready),
    .coef_addr(coef_addr), .coef_data(coef_data),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
  );

  int checks = 0;
  int errors = 0;
  int obs_coef = 0, obs_wr = 0, obs_rd = 0;
  bit model_pending = 0;
  logic [AW+DW-1:0] exp_coef[$];
  logic [12:0]      exp_wr[$];
  logic [4:0]       exp_rd[$];
  logic [7:0]       tx_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit reg_code(input logic [6:0] c);
    return ((c >= 7'h40) && (c <= 7'h4D)) || ((c >= 7'h50) && (c <= 7'h57));
  endfunction

  // Monitor: every clock, compare port events with the model's expectations.
  always @(negedge clk) begin
    if (rst_n) begin
      if (coef_valid && coef_ready) begin
        obs_coef++;
        if (exp_coef.size() == 0) chk(0, "R6", "unexpected coef write", {coef_addr, coef_data}, 0);
        else begin
          logic [AW+DW-1:0] e;
          e = exp_coef.pop_front();
          chk({coef_addr, coef_data} == e, "R4/R5", "coef addr:data", {coef_addr, coef_data}, e);
        end
      end
      if (reg_wr_en) begin
        obs_wr++;
        if (exp_wr.size() == 0) chk(0, "R10", "unexpected reg write", {reg_wr_addr, reg_wr_data}, 0);
        else begin
          logic [12:0] e;
          e = exp_wr.pop_front();
          chk({reg_wr_addr, reg_wr_data} == e, "R2/R10", "reg write", {reg_wr_addr, reg_wr_data}, e);
        end
      end
      if (reg_rd_en) begin
        obs_rd++;
        if (exp_rd.size() == 0) chk(0, "R9", "unexpected reg read", reg_rd_addr, 0);
        else begin
          logic [4:0] e;
          e = exp_rd.pop_front();
          chk(reg_rd_addr == e, "R9", "reg read index", reg_rd_addr, e);
        end
      end
    end
  end

  // Behavioural decode of the bytes the host will send completely.
  task automatic model(input int nfull, output bit rd_on, output logic [7:0] rdb);
    logic [7:0] c;
    logic [AW-1:0] a;
    rd_on = 0;
    rdb = 0;
    if (nfull == 0 || model_pending) return;   // R8: busy at command time
    c = tx_q[0];
    if (c[7:4] == 4'h8) begin
      if (nfull >= 3) begin
        a = {tx_q[1][3:0], tx_q[2]};
        for (int w = 0; w < (nfull - 3) / 3 && w < int'(c[3:0]) + 1; w++) begin
          if (!model_pending) begin
            exp_coef.push_back({a, tx_q[3+3*w], tx_q[4+3*w], tx_q[5+3*w]});
            if (stall) model_pending = 1;
          end
          a = a + 1'b1;
        end
      end
    end else if (reg_code(c[6:0])) begin
      if (c[7]) begin
        if (nfull >= 2) exp_wr.push_back({c[4:0], tx_q[1]});
      end else begin
        exp_rd.push_back(c[4:0]);
        rd_on = 1;
        rdb = {3'b101, c[4:0]};
      end
    end
  endtask

  // Send tx_q (nbits < 0: all bits) and check host_sdo in every bit period.
  task automatic txn(input int nbits_in);
    int nbits;
    bit rd_on;
    logic [7:0] rdb;
    bit stream[$];
    nbits = (nbits_in < 0) ? tx_q.size() * 8 : nbits_in;
    model(nbits / 8, rd_on, rdb);
    sel_n = 0;
    repeat (4) @(negedge clk);
    for (int m = 0; m < nbits; m++) begin
      bit b;
      bit e;
      b = tx_q[m/8][7 - (m % 8)];
      sdi = b;
      sclk = 0;
      repeat (4) @(negedge clk);
      if (rd_on && m >= 8 && m < 16) begin
        e = rdb[15 - m];
        chk(host_sdo === e, "R9", "read data bit", host_sdo, e);
      end else begin
        e = (m < 8) ? 1'b0 : stream[m-8];
        chk(host_sdo === e, "R3", "echo bit", host_sdo, e);
      end
      sclk = 1;
      stream.push_back(b);
      repeat (4) @(negedge clk);
    end
    sclk = 0;
    repeat (4) @(negedge clk);
    sel_n = 1;
    repeat (12) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int c0;
    rst_n = 0; sclk = 0; sdi = 0; sel_n = 1; stall = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(host_rdy === 1'b1, "R1", "rdy after reset", host_rdy, 1);
    chk(host_sdo === 1'b0, "R1", "sdo after reset", host_sdo, 0);
    chk(coef_valid === 1'b0, "R1", "valid after reset", coef_valid, 0);
    chk(!reg_wr_en && !reg_rd_en, "R1", "strobes after reset", {reg_wr_en, reg_rd_en}, 0);

    // R4 R5 R6: 3-word burst, 4 words sent, upper address nibble ignored
    c0 = obs_coef;
    tx_q = '{8'h82, 8'hA1, 8'h23, 8'h12, 8'h34, 8'h56, 8'hAB, 8'hCD, 8'hEF,
             8'h00, 8'hFF, 8'h01, 8'h77, 8'h88, 8'h99};
    txn(-1);
    chk(obs_coef == c0 + 3, "R6", "burst word count", obs_coef - c0, 3);

    // R5 address wrap
    tx_q = '{8'h81, 8'h0F, 8'hFF, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
    txn(-1);

    // R4 R6 longest burst plus one extra word
    c0 = obs_coef;
    tx_q = '{8'h8F, 8'h02, 8'h00};
    for (int w = 0; w < 17; w++) begin
      tx_q.push_back(8'(w * 7));
      tx_q.push_back(8'(8'hC0 ^ w));
      tx_q.push_back(8'(w + 8'h30));
    end
    txn(-1);
    chk(obs_coef == c0 + 16, "R6", "16-word burst count", obs_coef - c0, 16);

    // R10 register writes, extra byte ignored
    c0 = obs_wr;
    tx_q = '{8'hC3, 8'h5A, 8'h77};
    txn(-1);
    tx_q = '{8'hD7, 8'hA5};
    txn(-1);
    chk(obs_wr == c0 + 2, "R10", "reg write count", obs_wr - c0, 2);

    // R9 register reads, echo resumes after the data slot
    tx_q = '{8'h45, 8'h00, 8'h3C};
    txn(-1);
    tx_q = '{8'h57, 8'hFF};
    txn(-1);
    tx_q = '{8'h40, 8'h81};
    txn(-1);

    // R11 codes outside the decoded ranges
    c0 = obs_wr + obs_rd + obs_coef;
    tx_q = '{8'h30, 8'h11}; txn(-1);
    tx_q = '{8'h4E, 8'h22}; txn(-1);
    tx_q = '{8'hCE, 8'h33}; txn(-1);
    tx_q = '{8'h90, 8'h00, 8'h10, 8'h01, 8'h02, 8'h03}; txn(-1);
    chk(obs_wr + obs_rd + obs_coef == c0, "R11", "strobes for unknown codes", obs_wr + obs_rd + obs_coef - c0, 0);

    // R12 abort in the middle of the second word, then a fresh transaction
    c0 = obs_coef;
    tx_q = '{8'h81, 8'h00, 8'h40, 8'h0A, 8'h0B, 8'h0C, 8'h1A, 8'h1B, 8'h1C};
    txn(3 * 8 + 3 * 8 + 12);
    chk(obs_coef == c0 + 1, "R12", "words after abort", obs_coef - c0, 1);
    tx_q = '{8'hC1, 8'h3E};
    txn(-1);

    // R7 R8 back-pressure
    stall = 1;
    c0 = obs_coef;
    tx_q = '{8'h81, 8'h00, 8'h10, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    txn(-1);
    chk(host_rdy === 1'b0, "R7", "rdy while word pending", host_rdy, 0);
    chk(coef_valid && coef_addr == 12'h010 && coef_data == 24'h112233, "R7", "held word",
        {coef_valid, coef_addr, coef_data}, {1'b1, 12'h010, 24'h112233});
    c0 = obs_wr;
    tx_q = '{8'hC3, 8'h99};
    txn(-1);
    chk(obs_wr == c0, "R8", "reg write while busy", obs_wr - c0, 0);
    stall = 0;
    model_pending = 0;
    repeat (4) @(negedge clk);
    chk(host_rdy === 1'b1, "R7", "rdy after release", host_rdy, 1);
    chk(exp_coef.size() == 0, "R7", "pending word delivered", exp_coef.size(), 0);
    tx_q = '{8'hC3, 8'h99};
    txn(-1);

    repeat (10) @(negedge clk);
    chk(exp_coef.size() == 0, "R5", "coef queue drained", exp_coef.size(), 0);
    chk(exp_wr.size() == 0, "R10", "reg write queue drained", exp_wr.size(), 0);
    chk(exp_rd.size() == 0, "R9", "reg read queue drained", exp_rd.size(), 0);
    summary();
    $finish;
  end

endmodule